// File: doc/BRIEF.md
# BCD Clock and Calendar Counter Chain

This block keeps time of day and the calendar as packed BCD bytes: seconds, minutes, hours (24-hour), weekday, date, month and a two-digit year. It advances by one second on each cycle in which the 1 Hz tick enable is high. Carries ripple from seconds up through the year within that same cycle. A day carry also steps the weekday, which runs independently of the date. The last date of each month follows its length, and February takes 29 days when the year is a multiple of four. A century flag sits in bit 7 of the month byte and flips when the year wraps from 99 to 00.

Software loads any field through a single-cycle write port, and unused bit positions are cleared on the way in. A stop input freezes the chain. The tick source is external and keeps running while the chain is frozen, so releasing stop resumes counting from the held value.

Top module: `rtc_calendar_chain`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every field reads 00, including the century flag.
- R2: Each cycle with tick_en=1, stop=0 and wr_en=0 adds one second in BCD. Seconds and minutes wrap 59→00 and hours wrap 23→00, each wrap carrying into the next field in the same cycle.
- R3: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in every other month except 02. Each such wrap advances the month.
- R4: In month 02 the date wraps after 29 when the year, read as a decimal number, is a multiple of 4 (00 included), and after 28 otherwise.
- R5: A date wrap in month 12 sets the month to 01 and advances the year. The year wraps 99→00, and that wrap toggles the century flag in bit 7 of the month byte.
- R6: Every day carry advances the weekday, which wraps from 06 to 00 without regard to the date.
- R7: While stop=1 no field changes, whatever tick_en does. After stop is released, the first tick adds exactly one second to the held value.
- R8: With wr_en=1, the field chosen by wr_sel is loaded (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month with century, 6 year). No field advances in that cycle, even if tick_en=1. wr_sel=7 changes nothing.
- R9: A write keeps only the implemented bits: seconds and minutes 6:0, hours and date 5:0, weekday 2:0, month 7 and 4:0, year 7:0. All other bits read 0.
- R10: A cycle with tick_en=0 and wr_en=0 changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-second advance enable |
| stop | input | 1 | Freezes the counter chain when 1 |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for a write |
| wr_data | input | 8 | Write value, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD |
| wday_o | output | 8 | Weekday, BCD |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Century flag in bit 7, BCD month in bits 4:0 |
| year_o | output | 8 | Year, BCD |

## Verification
The hardest situations to reach are the ones that need a full carry from seconds into the month and year: the end of February in leap and non-leap years, the end of a 30-day month, and the year wrap that flips the century flag. Counting up to them would take millions of ticks. The stimulus instead loads 23:59:59 and the target date through the write port and then gives one tick. Random phases mix ticks, stops and field writes of values near each boundary. A behavioural model checks every cycle, so ticks that coincide with writes or stops are covered too.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int DW         = 8;
    localparam int NUM_FIELDS = 7;
    localparam int SEL_W      = 3;

    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_WDAY  = 3;
    localparam int F_DATE  = 4;
    localparam int F_MONTH = 5;
    localparam int F_YEAR  = 6;

    localparam logic [SEL_W-1:0] SEL_NONE = 3'd7;
    localparam int               CENT_BIT = 7;

    typedef logic [NUM_FIELDS-1:0][DW-1:0] cal_regs_t;

    typedef struct packed {
        cal_regs_t f;
    } cal_state_t;

    // implemented bits per field
    function automatic logic [DW-1:0] field_mask(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0, 3'd1: field_mask = 8'h7F;
            3'd2, 3'd4: field_mask = 8'h3F;
            3'd3:       field_mask = 8'h07;
            3'd5:       field_mask = 8'h9F;
            3'd6:       field_mask = 8'hFF;
            default:    field_mask = 8'h00;
        endcase
    endfunction

    // fixed upper limits; the date limit is computed at run time
    function automatic logic [DW-1:0] field_limit(input int idx);
        case (idx)
            F_SEC, F_MIN: field_limit = 8'h59;
            F_HOUR:       field_limit = 8'h23;
            F_WDAY:       field_limit = 8'h06;
            F_MONTH:      field_limit = 8'h12;
            default:      field_limit = 8'h99;
        endcase
    endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
    parameter int           W     = 8,
    parameter logic [W-1:0] FLOOR = '0
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] limit_i,
    input  logic         inc_i,
    output logic [W-1:0] nxt_o,
    output logic         at_lim_o
);
    localparam int HW = W - 4;

    logic [W-1:0] plus_one;

    always_comb begin
        at_lim_o = (cur_i >= limit_i);
        if (cur_i[3:0] >= 4'd9) begin
            plus_one = {cur_i[W-1:4] + HW'(1), 4'h0};
        end else begin
            plus_one = cur_i + W'(1);
        end
        nxt_o = cur_i;
        if (inc_i) begin
            nxt_o = at_lim_o ? FLOOR : plus_one;
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [4:0] month_i,
    input  logic [7:0] year_i,
    output logic [7:0] last_o
);
    logic [6:0] year_bin;
    logic       leap;

    always_comb begin
        year_bin = {3'b000, year_i[7:4]} * 7'd10 + {3'b000, year_i[3:0]};
        leap     = ((year_bin & 7'h03) == 7'h00);
        case (month_i)
            5'h02:                      last_o = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_o = 8'h30;
            default:                    last_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chain.sv
module rtc_calendar_chain
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             stop,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    sec_o,
    output logic [DW-1:0]    min_o,
    output logic [DW-1:0]    hour_o,
    output logic [DW-1:0]    wday_o,
    output logic [DW-1:0]    date_o,
    output logic [DW-1:0]    month_o,
    output logic [DW-1:0]    year_o
);
    cal_state_t              st_d, st_q;
    cal_regs_t               cur, lim, nxt;
    logic [NUM_FIELDS-1:0]   en, at_lim;
    logic [DW-1:0]           last_day;
    logic                    step;
    logic                    day_carry;
    logic                    cent_next;

    assign step = tick_en & ~stop & ~wr_en;

    rtc_month_len u_mlen (
        .month_i (st_q.f[F_MONTH][4:0]),
        .year_i  (st_q.f[F_YEAR]),
        .last_o  (last_day)
    );

    always_comb begin
        cur          = st_q.f;
        cur[F_MONTH] = {3'b000, st_q.f[F_MONTH][4:0]};
        for (int i = 0; i < NUM_FIELDS; i++) begin
            lim[i] = field_limit(i);
        end
        lim[F_DATE] = last_day;
    end

    // enables built straight from the limit flags, no self reference
    always_comb begin
        day_carry   = step & at_lim[F_SEC] & at_lim[F_MIN] & at_lim[F_HOUR];
        en          = '0;
        en[F_SEC]   = step;
        en[F_MIN]   = step & at_lim[F_SEC];
        en[F_HOUR]  = step & at_lim[F_SEC] & at_lim[F_MIN];
        en[F_WDAY]  = day_carry;
        en[F_DATE]  = day_carry;
        en[F_MONTH] = day_carry & at_lim[F_DATE];
        en[F_YEAR]  = day_carry & at_lim[F_DATE] & at_lim[F_MONTH];
        cent_next   = st_q.f[F_MONTH][CENT_BIT] ^ (en[F_YEAR] & at_lim[F_YEAR]);
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_step
        localparam logic [DW-1:0] FLR = (g == F_DATE || g == F_MONTH) ? 8'h01 : 8'h00;
        rtc_bcd_step #(.W(DW), .FLOOR(FLR)) u_step (
            .cur_i    (cur[g]),
            .limit_i  (lim[g]),
            .inc_i    (en[g]),
            .nxt_o    (nxt[g]),
            .at_lim_o (at_lim[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_sel != SEL_NONE) begin
                st_d.f[wr_sel] = wr_data & field_mask(wr_sel);
            end
        end else if (step) begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                st_d.f[i] = nxt[i];
            end
            st_d.f[F_MONTH] = nxt[F_MONTH] | {cent_next, 7'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o   = st_q.f[F_SEC];
    assign min_o   = st_q.f[F_MIN];
    assign hour_o  = st_q.f[F_HOUR];
    assign wday_o  = st_q.f[F_WDAY];
    assign date_o  = st_q.f[F_DATE];
    assign month_o = st_q.f[F_MONTH];
    assign year_o  = st_q.f[F_YEAR];

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (st_q.f == '0));

    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sec_o == 8'h59) |=> (sec_o == 8'h00));

    assert_century_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (month_o[CENT_BIT] != $past(month_o[CENT_BIT])) |->
        ($past(wr_en) || ($past(year_o) == 8'h99 && year_o == 8'h00)));

    assert_wday_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && wday_o == 8'h06) |=> (wday_o == 8'h00));

    assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !wr_en) |=> $stable(st_q.f));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != SEL_NONE) |=>
        (st_q.f[$past(wr_sel)] == ($past(wr_data) & field_mask($past(wr_sel)))));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(st_q.f));
endmodule

// File: tb/rtc_calendar_chain_tb.sv
module rtc_calendar_chain_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    // behavioural model: binary integers
    int m_val [7];
    int m_cent;

    always #2 clk = ~clk;

    rtc_calendar_chain u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stop(stop),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int month_days(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] keep_bits(input int sel);
        case (sel)
            0, 1: return 8'h7F;
            2, 4: return 8'h3F;
            3:    return 8'h07;
            5:    return 8'h9F;
            6:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) m_val[i] = 0;
            m_cent = 0;
        end else if (wr_en) begin
            if (wr_sel != 3'd7) begin
                logic [7:0] k;
                k = wr_data & keep_bits(int'(wr_sel));
                if (wr_sel == 3'd5) begin
                    m_cent = int'(k[7]);
                    m_val[5] = from_bcd({3'b000, k[4:0]});
                end else begin
                    m_val[wr_sel] = from_bcd(k);
                end
            end
        end else if (tick_en && !stop) begin
            m_val[0]++;
            if (m_val[0] > 59) begin
                m_val[0] = 0; m_val[1]++;
                if (m_val[1] > 59) begin
                    m_val[1] = 0; m_val[2]++;
                    if (m_val[2] > 23) begin
                        m_val[2] = 0;
                        m_val[3] = (m_val[3] >= 6) ? 0 : m_val[3] + 1;
                        if (m_val[4] >= month_days(m_val[5], m_val[6])) begin
                            m_val[4] = 1;
                            if (m_val[5] >= 12) begin
                                m_val[5] = 1;
                                if (m_val[6] >= 99) begin
                                    m_val[6] = 0;
                                    m_cent = 1 - m_cent;
                                end else m_val[6]++;
                            end else m_val[5]++;
                        end else m_val[4]++;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model comparison every cycle
    always @(negedge clk) begin
        if (cmp_on && rst_n && !finished) begin
            logic [7:0] e [7];
            logic [7:0] a [7];
            for (int i = 0; i < 7; i++) e[i] = to_bcd(m_val[i]);
            e[5] = e[5] | (m_cent != 0 ? 8'h80 : 8'h00);
            a[0] = sec_o; a[1] = min_o; a[2] = hour_o; a[3] = wday_o;
            a[4] = date_o; a[5] = month_o; a[6] = year_o;
            total++;
            for (int i = 0; i < 7; i++) begin
                if (a[i] !== e[i]) begin
                    bad++;
                    $display("FAIL model R2 field %0d actual=%h expected=%h", i, a[i], e[i]);
                    break;
                end
            end
        end
    end

    task automatic wr(input int sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic set_all(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                           input logic [7:0] wd, input logic [7:0] dt,
                           input logic [7:0] mo, input logic [7:0] yr);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, wd); wr(4, dt); wr(5, mo); wr(6, yr);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 8'h00, 8'h01);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset sec", sec_o, 8'h00);
        check("R1 reset month", month_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        check("R1 after reset year", year_o, 8'h00);
        check("R1 after reset date", date_o, 8'h00);

        // R2 basic count and carry
        set_all(8'h10, 8'h59, 8'h58, 8'h02, 8'h15, 8'h07, 8'h21);
        tick1();
        check("R2 sec 58->59", sec_o, 8'h59);
        tick1();
        check("R2 sec wrap", sec_o, 8'h00);
        check("R2 min wrap", min_o, 8'h00);
        check("R2 hour carry", hour_o, 8'h11);

        // R10 idle cycles
        repeat (5) @(negedge clk);
        check("R10 idle hold", sec_o, 8'h00);

        // R3 30-day month
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h21);
        tick1();
        check("R3 apr30 date", date_o, 8'h01);
        check("R3 apr30 month", month_o, 8'h05);
        check("R2 hour 23 wrap", hour_o, 8'h00);
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h01, 8'h21);
        tick1();
        check("R3 jan30 stays", date_o, 8'h31);
        check("R3 jan month", month_o, 8'h01);

        // R4 February
        set_all(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h23);
        tick1();
        check("R4 nonleap date", date_o, 8'h01);
        check("R4 nonleap month", month_o, 8'h03);
        set_all(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h24);
        tick1();
        check("R4 leap 29", date_o, 8'h29);
        set_all(8'h23, 8'h59, 8'h59, 8'h03, 8'h29, 8'h02, 8'h00);
        tick1();
        check("R4 year00 29 wrap", date_o, 8'h01);
        check("R4 year00 month", month_o, 8'h03);

        // R5 / R6 year and century wrap, weekday wrap
        set_all(8'h23, 8'h59, 8'h59, 8'h06, 8'h31, 8'h12, 8'h99);
        tick1();
        check("R5 year wrap", year_o, 8'h00);
        check("R5 century set", month_o, 8'h81);
        check("R6 wday wrap", wday_o, 8'h00);
        check("R5 date", date_o, 8'h01);

        // R7 stop
        wr(0, 8'h30);
        @(negedge clk);
        stop = 1'b1; tick_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 frozen", sec_o, 8'h30);
        stop = 1'b0;
        @(negedge clk);
        tick_en = 1'b0;
        check("R7 resume one step", sec_o, 8'h31);

        // R8 write wins over tick; sel 7 ignored
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h10; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        check("R8 write wins", sec_o, 8'h10);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd7; wr_data = 8'h45; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        check("R8 sel7 ignored", sec_o, 8'h10);

        // R9 masks
        wr(2, 8'hE3);
        check("R9 hour mask", hour_o, 8'h23);
        wr(3, 8'hFD);
        check("R9 wday mask", wday_o, 8'h05);
        wr(5, 8'hF2);
        check("R9 month mask", month_o, 8'h92);

        // random phase against the model
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            tick_en = ($urandom % 8) != 0;
            stop    = ($urandom % 12) == 0;
            wr_en   = ($urandom % 6) == 0;
            wr_sel  = 3'($urandom % 8);
            case (wr_sel)
                3'd0, 3'd1: wr_data = to_bcd(($urandom % 3 == 0) ? 59 : int'($urandom % 60));
                3'd2:       wr_data = to_bcd(($urandom % 2 == 0) ? 23 : int'($urandom % 24));
                3'd3:       wr_data = to_bcd(int'($urandom % 7));
                3'd4:       wr_data = to_bcd(28 + int'($urandom % 4));
                3'd5:       wr_data = to_bcd(1 + int'($urandom % 12)) | (($urandom % 2) ? 8'h80 : 8'h00);
                default:    wr_data = to_bcd(($urandom % 2 == 0) ? 99 : int'($urandom % 100));
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0; stop = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule